// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the single 32-bit status and configuration word of a floating-point unit. Software reads it and writes it over a simple bus port. The arithmetic datapath reports exception events on a per-operation flag port, and compare operations deliver their condition code on a separate port. The word holds four pieces of state:

- the live mode controls: alternative half-precision, default NaN, flush-to-zero and rounding mode;
- four condition bits;
- six sticky exception flags;
- a reserved remainder that always reads as zero.

A companion default-mode register holds the mode values that are loaded at reset and on every context start.

Five of the six exception flags are combined by an OR into one registered interrupt request, which has no per-flag mask. The inexact flag is left out of that OR and can only be polled. Flag and condition inputs are qualified by a valid strobe and are accepted in every cycle. There is no back-pressure on any input, so a producer never waits, and a strobe that is low means that no event arrived.

Top module: `fpu_status_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_rdata` reads as 0, `irq` is 0 and `dflt_rdata` reads as 0. The default reset mode value is all zeros.
- R2: A cycle with `cmp_valid` high loads `cmp_nzcv` into bits 31:28 at the next clock edge. `cmp_nzcv[3]` goes to bit 31 (negative), and so on down to `cmp_nzcv[0]` at bit 28 (overflow).
- R3: Bits 31:28 change only through `cmp_valid`. A bus write leaves them unchanged, and so does a cycle without a compare.
- R4: A bus write copies `bus_wdata[26:22]` into the live mode field. Bit 26 is alternative half-precision, bit 25 is default NaN, bit 24 is flush-to-zero, and bits 23:22 are the rounding mode.
- R5: When `op_valid` is high, each set bit of `op_flags` sets one exception flag. The mapping is: bit 0 to invalid (register bit 0), bit 1 to divide-by-zero (bit 1), bit 2 to overflow (bit 2), bit 3 to underflow (bit 3), bit 4 to inexact (bit 4), and bit 5 to input-denormal (bit 7).
- R6: Exception flags are sticky. They keep their value through later operations. Only a bus write changes them: it loads the corresponding `bus_wdata` bit, so writing 0 clears a flag and writing 1 sets it.
- R7: When a bus write clears a flag in the same cycle that the datapath sets it, the flag ends up set.
- R8: `irq` is registered. It is high in the cycle after any of the flags input-denormal, underflow, overflow, divide-by-zero or invalid is set, and it stays high while any of them remains set. It falls in the cycle after the last of them is cleared.
- R9: The inexact flag (bit 4) never raises `irq`.
- R10: The reserved bits 27, 21:8 and 6:5 read as 0 and ignore writes.
- R11: `dflt_wr_en` stores `bus_wdata[26:22]` in the default-mode register. `dflt_rdata` shows that value at bits 26:22 and 0 everywhere else. `ctx_load` copies the current default value into the live mode field, and it takes precedence over a bus write in the same cycle.
- R12: `op_flags` has no effect while `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe for the status/control word |
| bus_wdata | input | 32 | Write data, shared by both registers |
| bus_rdata | output | 32 | Current status/control word |
| dflt_wr_en | input | 1 | Write strobe for the default-mode register |
| dflt_rdata | output | 32 | Current default-mode register |
| ctx_load | input | 1 | Context start: reload live modes from the defaults |
| op_valid | input | 1 | Datapath flag report is valid |
| op_flags | input | 6 | Exception events of one operation |
| cmp_valid | input | 1 | Compare result is valid |
| cmp_nzcv | input | 4 | Condition code from a compare |
| irq | output | 1 | Exception interrupt request (level) |

## Verification
Every register update appears on `bus_rdata` and `dflt_rdata` one edge after the stimulus cycle. The same holds for the condition bits, the mode fields, the flags and the default value. `irq` follows the flags one edge later still, so it reflects the flag state of the previous cycle. The driver applies each stimulus at a falling edge and queues what the word should read after the next rising edge. For `irq`, the queued value is computed from the flag state that held before that edge. The monitor compares the queued item 1 ns after that rising edge. Because of this, every expectation lands on the exact cycle in which its result is due.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned COND_LSB = 28;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned MODE_LSB = 22;
  localparam int unsigned NFLAG    = 6;
  localparam int unsigned INEXACT_IDX = 4;
  // flags that drive the interrupt: everything except inexact
  localparam logic [NFLAG-1:0] IRQ_FLAGS = 6'b101111;

  typedef struct packed {
    logic       alt_half;
    logic       dflt_nan;
    logic       flush0;
    logic [1:0] rnd;
  } mode_t;

  // register bit position of flag index i
  function automatic int unsigned flag_pos(input int unsigned i);
    case (i)
      0: flag_pos = 0;
      1: flag_pos = 1;
      2: flag_pos = 2;
      3: flag_pos = 3;
      4: flag_pos = 4;
      default: flag_pos = 7;
    endcase
  endfunction
endpackage

// File: rtl/fpsr_mode_bank.sv
module fpsr_mode_bank #(
  parameter int unsigned W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live_wr,
  input  logic         dflt_wr,
  input  logic         ctx_load,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] live,
  output logic [W-1:0] dflt
);
  logic [W-1:0] dflt_q, live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dflt_q <= RST_VAL;
    else if (dflt_wr) dflt_q <= wdata;
  end

  // context start takes precedence over a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        live_q <= RST_VAL;
    else if (ctx_load) live_q <= dflt_q;
    else if (live_wr)  live_q <= wdata;
  end

  assign live = live_q;
  assign dflt = dflt_q;
endmodule

// File: rtl/fpsr_cond_bank.sv
module fpsr_cond_bank #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_vld,
  input  logic [W-1:0] cmp_code,
  output logic [W-1:0] cond
);
  logic [W-1:0] cond_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cond_q <= '0;
    else if (cmp_vld) cond_q <= cmp_code;
  end
  assign cond = cond_q;
endmodule

// File: rtl/fpsr_sticky_bank.sv
module fpsr_sticky_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_wr,
  input  logic [N-1:0] sw_val,
  input  logic         set_vld,
  input  logic [N-1:0] set_val,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic bit_q;
    // a datapath set beats a software clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     bit_q <= 1'b0;
      else if (set_vld && set_val[g]) bit_q <= 1'b1;
      else if (sw_wr)                 bit_q <= sw_val[g];
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/fpsr_irq_gen.sv
module fpsr_irq_gen #(
  parameter int unsigned N = 6,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  output logic         irq
);
  logic irq_q;
  logic [N-1:0] contrib;
  assign contrib = flags & MASK;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |contrib;
  end
  assign irq = irq_q;
endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
  import fpsr_pkg::*;
#(
  parameter logic [MODE_W-1:0] DFLT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              dflt_wr_en,
  output logic [REG_W-1:0]  dflt_rdata,
  input  logic              ctx_load,
  input  logic              op_valid,
  input  logic [NFLAG-1:0]  op_flags,
  input  logic              cmp_valid,
  input  logic [COND_W-1:0] cmp_nzcv,
  output logic              irq
);
  localparam int unsigned MODE_MSB = MODE_LSB + MODE_W - 1;
  localparam int unsigned COND_MSB = COND_LSB + COND_W - 1;

  mode_t              live_mode, dflt_mode;
  logic [MODE_W-1:0]  live_raw, dflt_raw;
  logic [COND_W-1:0]  cond;
  logic [NFLAG-1:0]   flags, sw_flag_val;
  logic               unused_wdata;

  // write data for the flags, gathered from their register positions
  for (genvar i = 0; i < NFLAG; i++) begin : g_wsel
    assign sw_flag_val[i] = bus_wdata[flag_pos(i)];
  end

  // bits that writes never reach: condition field and reserved bits
  assign unused_wdata = &{bus_wdata[COND_MSB:COND_LSB], bus_wdata[27],
                          bus_wdata[21:8], bus_wdata[6:5]};

  fpsr_mode_bank #(.W(MODE_W), .RST_VAL(DFLT_RESET)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .live_wr(bus_wr_en), .dflt_wr(dflt_wr_en), .ctx_load(ctx_load),
    .wdata(bus_wdata[MODE_MSB:MODE_LSB]),
    .live(live_raw), .dflt(dflt_raw)
  );

  fpsr_cond_bank #(.W(COND_W)) u_cond (
    .clk(clk), .rst_n(rst_n),
    .cmp_vld(cmp_valid), .cmp_code(cmp_nzcv), .cond(cond)
  );

  fpsr_sticky_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(bus_wr_en), .sw_val(sw_flag_val),
    .set_vld(op_valid), .set_val(op_flags), .q(flags)
  );

  fpsr_irq_gen #(.N(NFLAG), .MASK(IRQ_FLAGS)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags(flags), .irq(irq)
  );

  assign live_mode = mode_t'(live_raw);
  assign dflt_mode = mode_t'(dflt_raw);

  always_comb begin
    bus_rdata = '0;
    bus_rdata[COND_MSB:COND_LSB] = cond;
    bus_rdata[MODE_MSB:MODE_LSB] = live_mode;
    for (int i = 0; i < NFLAG; i++) bus_rdata[flag_pos(i)] = flags[i];
  end

  always_comb begin
    dflt_rdata = '0;
    dflt_rdata[MODE_MSB:MODE_LSB] = dflt_mode;
  end
endmodule

// File: rtl/fpsr_chk.sv
module fpsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic [31:0] bus_rdata,
  input logic [31:0] dflt_rdata,
  input logic        ctx_load,
  input logic        op_valid,
  input logic [5:0]  op_flags,
  input logic        cmp_valid,
  input logic [3:0]  cmp_nzcv,
  input logic        irq
);
  logic irq_src;
  assign irq_src = |{bus_rdata[7], bus_rdata[3:0]};

  a_r2_cond_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> bus_rdata[31:28] == $past(cmp_nzcv));

  a_r3_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(bus_rdata[31:28]));

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_en && bus_rdata[2]) |=> bus_rdata[2]);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_flags[1]) |=> bus_rdata[1]);

  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src |=> irq);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_src |=> !irq);

  a_r11_ctx_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> bus_rdata[26:22] == $past(dflt_rdata[26:22]));
endmodule

bind fpu_status_ctrl fpsr_chk u_fpsr_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rdata(bus_rdata),
  .dflt_rdata(dflt_rdata), .ctx_load(ctx_load), .op_valid(op_valid),
  .op_flags(op_flags), .cmp_valid(cmp_valid), .cmp_nzcv(cmp_nzcv), .irq(irq)
);

// File: tb/fpu_status_ctrl_tb_top.sv
module fpu_status_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dflt_wr_en = 1'b0;
  logic [31:0] dflt_rdata;
  logic        ctx_load = 1'b0;
  logic        op_valid = 1'b0;
  logic [5:0]  op_flags = '0;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_nzcv = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fpu_status_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dflt_wr_en(dflt_wr_en), .dflt_rdata(dflt_rdata),
    .ctx_load(ctx_load), .op_valid(op_valid), .op_flags(op_flags),
    .cmp_valid(cmp_valid), .cmp_nzcv(cmp_nzcv), .irq(irq)
  );

  typedef struct {
    logic [31:0] rd;
    logic        irq;
    logic [31:0] dr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference state, built from the requirements
  logic [4:0] m_mode = '0, m_dflt = '0;
  logic [3:0] m_cond = '0;
  logic [5:0] m_flag = '0;

  function automatic logic [31:0] pack_word();
    return {m_cond, 1'b0, m_mode, 14'b0, m_flag[5], 2'b0, m_flag[4:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input logic wr, input logic [31:0] wd, input logic dwr,
                      input logic ctx, input logic opv, input logic [5:0] opf,
                      input logic cv, input logic [3:0] nz, input string tag);
    exp_t e;
    logic nirq;
    @(negedge clk);
    bus_wr_en = wr; bus_wdata = wd; dflt_wr_en = dwr; ctx_load = ctx;
    op_valid = opv; op_flags = opf; cmp_valid = cv; cmp_nzcv = nz;
    nirq = |(m_flag & 6'b101111);
    m_flag = (wr ? {wd[7], wd[4:0]} : m_flag) | (opv ? opf : 6'b0);
    if (cv) m_cond = nz;
    m_mode = ctx ? m_dflt : (wr ? wd[26:22] : m_mode);
    if (dwr) m_dflt = wd[26:22];
    e.rd = pack_word(); e.irq = nirq; e.dr = {5'b0, m_dflt, 22'b0}; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  // monitor: compare each queued expectation after the edge it belongs to
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check({e.tag, " word"}, bus_rdata, e.rd);
      check({e.tag, " irq"}, {31'b0, irq}, {31'b0, e.irq});
      check({e.tag, " dflt"}, dflt_rdata, e.dr);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", bus_rdata, '0);
    check("R1 reset irq", {31'b0, irq}, '0);
    check("R1 reset dflt", dflt_rdata, '0);
    rst_n = 1'b1;
    idle("R1 after reset");
    step(0, '0, 0, 0, 0, '0, 1, 4'b1010, "R2 compare load");
    idle("R3 cond hold");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, '0, 0, '0, "R3 R4 R10 write all ones");
    idle("R8 irq after write set");
    step(1, 32'h0000_0000, 0, 0, 0, '0, 0, '0, "R6 write clears");
    idle("R8 irq falls");
    step(0, '0, 0, 0, 1, 6'b010000, 0, '0, "R9 inexact only");
    idle("R9 no irq");
    idle("R9 no irq later");
    step(1, 32'h0000_0000, 0, 0, 0, '0, 0, '0, "R6 clear inexact");
    step(0, '0, 0, 0, 0, 6'b111111, 0, '0, "R12 op_valid low");
    idle("R12 no irq");
    step(0, '0, 0, 0, 1, 6'b000100, 0, '0, "R5 overflow set");
    step(0, '0, 0, 0, 1, 6'b000000, 0, '0, "R6 sticky through op");
    step(0, '0, 0, 0, 1, 6'b100000, 1, 4'b0101, "R5 denormal to bit7");
    idle("R8 irq held");
    step(1, 32'h0000_0000, 0, 0, 1, 6'b000010, 0, '0, "R7 set beats clear");
    idle("R7 divzero kept");
    step(1, 32'h0000_0000, 0, 0, 0, '0, 0, '0, "R6 clear all");
    idle("R8 irq clears");
    step(1, 32'h0940_0000, 0, 0, 0, '0, 0, '0, "R4 mode write");
    step(0, 32'h02C0_0000, 1, 0, 0, '0, 0, '0, "R11 default write");
    step(1, 32'h0500_0000, 0, 1, 0, '0, 0, '0, "R11 ctx beats write");
    step(0, 32'hFC3F_FF6F, 1, 0, 0, '0, 0, '0, "R10 R11 dflt reserved");
    idle("R11 final");
    idle("drain");
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule